// File: doc/BRIEF.md
# Byte-Wide Asynchronous Memory Access Sequencer

This block turns a single command into one complete access cycle on a byte-wide asynchronous static memory. A requester presents a read or write request with an address and, for writes, a data byte. When the engine is parked it accepts the request and drives the three active-low strobes through a fixed three-step pattern. It drives the address pins throughout the cycle and, for writes, the data pins as well. It then returns to a parked pattern and signals completion.

Each of the three steps lasts a programmable number of clocks, so one piece of logic can meet the setup, pulse and hold times of slow and fast parts alike. For a read, the engine captures the data bus at the end of the strobe step and presents the byte together with a one-clock completion pulse. The bidirectional data bus appears as separate output, output-enable and input vectors. The pad ring combines them.

Top module: `sram_cycle_seq`

## Requirements
- R1: After reset and between accesses, the strobes read {oe_n,we_n,ce_n} = 3'b111, `cmd_ready` is 1 and `mem_dq_oe` is 0.
- R2: A write cycle drives {oe_n,we_n,ce_n} = 3'b110, then 3'b100, then 3'b110. Each step lasts the step length.
- R3: A read cycle drives {oe_n,we_n,ce_n} = 3'b110, then 3'b010, then 3'b110. Each step lasts the step length.
- R4: During all three steps of a write, `mem_addr` carries the command address, `mem_dq_out` carries the write byte and `mem_dq_oe` is 1. `mem_dq_oe` returns to 0 in the first parked clock.
- R5: During all three steps of a read, `mem_addr` carries the command address and `mem_dq_oe` stays 0.
- R6: A read captures `mem_dq_in` at the clock edge that ends the last clock of the middle step. Values on the bus in any other clock have no effect on the returned byte.
- R7: The step length equals `hold_cycles` sampled when the command is accepted. A value of 0 gives one clock. Changes to `hold_cycles` during a cycle have no effect.
- R8: `cmd_ready` is 0 from the first step to the last. A request presented in that time is not taken, and its address, data, direction and length do not reach the pins.
- R9: `done` is high for exactly one clock, the first parked clock after the third step. For a read, `rdata` holds the captured byte in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Engine parked, request will be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W (8) | Access address |
| cmd_wdata | input | DATA_W (8) | Write byte |
| hold_cycles | input | CNT_W (4) | Clocks per step, 0 treated as 1 |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W (8) | Captured read byte |
| mem_addr | output | ADDR_W (8) | Memory address pins |
| mem_dq_out | output | DATA_W (8) | Data pins, outgoing value |
| mem_dq_oe | output | 1 | Data pin driver enable |
| mem_dq_in | input | DATA_W (8) | Data pins, incoming value |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ce_n | output | 1 | Chip enable, active low |

## Verification
The bench writes every address and reads every address back at several step lengths, including the zero length. A design that does not clamp a zero length would hang or wrap its step counter. During reads, the bench presents the true byte only in the final middle-step clock and its complement in every other clock. A design that samples one clock early or late therefore returns an inverted byte. Throughout each cycle the bench keeps a conflicting request asserted and changes the step length. A design that re-samples the command or the length mid-cycle would then show wrong pins or wrong step lengths. The bench also checks `done` in the clocks around its pulse, which catches a pulse that is held, doubled or shifted by one clock.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
   typedef enum logic [1:0] {
      PH_PARK    = 2'd0,
      PH_LEAD    = 2'd1,
      PH_STROBE  = 2'd2,
      PH_TRAIL   = 2'd3
   } phase_e;

   // strobe words ordered {oe_n, we_n, ce_n}
   localparam logic [2:0] PAT_PARK  = 3'b111;
   localparam logic [2:0] PAT_EDGE  = 3'b110;
   localparam logic [2:0] PAT_WRITE = 3'b100;
   localparam logic [2:0] PAT_READ  = 3'b010;
endpackage

// File: rtl/seq_phase_ctl.sv
module seq_phase_ctl
   import sram_seq_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] hold_cycles,
   output phase_e           phase,
   output logic             last_tick,
   output logic             finish
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] len_eff;

   assign len_eff   = (hold_cycles == '0) ? ONE : hold_cycles;
   assign last_tick = (phase_q != PH_PARK) && (cnt_q == '0);
   assign finish    = last_tick && (phase_q == PH_TRAIL);
   assign phase     = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_PARK;
         cnt_q   <= '0;
         len_q   <= ONE;
      end else if (phase_q == PH_PARK) begin
         if (start) begin
            phase_q <= PH_LEAD;
            cnt_q   <= len_eff - ONE;
            len_q   <= len_eff;
         end
      end else if (cnt_q == '0) begin
         cnt_q <= len_q - ONE;
         unique case (phase_q)
            PH_LEAD:   phase_q <= PH_STROBE;
            PH_STROBE: phase_q <= PH_TRAIL;
            default:   phase_q <= PH_PARK;
         endcase
      end else begin
         cnt_q <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/seq_cmd_regs.sv
module seq_cmd_regs
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  phase_e            phase,
   input  logic              last_tick,
   input  logic              finish,
   input  logic [DATA_W-1:0] dq_in,
   output logic              write_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              done_q
);
   logic capture;
   assign capture = last_tick && (phase == PH_STROBE) && !write_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         write_q <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish;
         if (start) begin
            write_q <= cmd_write;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
         end
         if (capture) rdata_q <= dq_in;
      end
   end
endmodule

// File: rtl/seq_pin_drive.sv
module seq_pin_drive
   import sram_seq_pkg::*;
(
   input  phase_e phase,
   input  logic   write_q,
   output logic   oe_n,
   output logic   we_n,
   output logic   ce_n,
   output logic   dq_oe
);
   logic [2:0] pat;

   always_comb begin
      unique case (phase)
         PH_PARK:   pat = PAT_PARK;
         PH_STROBE: pat = write_q ? PAT_WRITE : PAT_READ;
         default:   pat = PAT_EDGE;
      endcase
   end

   assign {oe_n, we_n, ce_n} = pat;
   assign dq_oe = write_q && (phase != PH_PARK);
endmodule

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [CNT_W-1:0]  hold_cycles,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_ce_n
);
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_cycle_seq: bus widths must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("sram_cycle_seq: CNT_W must lie in 1..16");
   end

   phase_e phase;
   logic   last_tick;
   logic   finish;
   logic   start;
   logic   write_q;

   assign cmd_ready = (phase == PH_PARK);
   assign start     = cmd_valid && cmd_ready;

   seq_phase_ctl #(.CNT_W(CNT_W)) i_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .hold_cycles (hold_cycles),
      .phase       (phase),
      .last_tick   (last_tick),
      .finish      (finish)
   );

   seq_cmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cmd_write (cmd_write),
      .cmd_addr  (cmd_addr),
      .cmd_wdata (cmd_wdata),
      .phase     (phase),
      .last_tick (last_tick),
      .finish    (finish),
      .dq_in     (mem_dq_in),
      .write_q   (write_q),
      .addr_q    (mem_addr),
      .wdata_q   (mem_dq_out),
      .rdata_q   (rdata),
      .done_q    (done)
   );

   seq_pin_drive i_pins (
      .phase   (phase),
      .write_q (write_q),
      .oe_n    (mem_oe_n),
      .we_n    (mem_we_n),
      .ce_n    (mem_ce_n),
      .dq_oe   (mem_dq_oe)
   );
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              done,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_ce_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr
);
   assert_park_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (mem_oe_n && mem_we_n && mem_ce_n && !mem_dq_oe));

   assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe);

   assert_read_floats_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

   assert_addr_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !cmd_ready);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(!mem_ce_n) && mem_ce_n));
endmodule

bind sram_cycle_seq sram_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .done      (done),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_ce_n  (mem_ce_n),
   .mem_dq_oe (mem_dq_oe),
   .mem_addr  (mem_addr)
);

// File: tb/test_sram_cycle_seq.sv
module test_sram_cycle_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic       cmd_write = 1'b0;
   logic [7:0] cmd_addr = '0;
   logic [7:0] cmd_wdata = '0;
   logic [3:0] hold_cycles = 4'd1;
   logic       done;
   logic [7:0] rdata;
   logic [7:0] mem_addr;
   logic [7:0] mem_dq_out;
   logic       mem_dq_oe;
   logic [7:0] mem_dq_in = '0;
   logic       mem_oe_n, mem_we_n, mem_ce_n;

   int vectors = 0;
   int misses  = 0;
   bit finished = 1'b0;
   logic [7:0] model [256];

   always #10 clk = ~clk;

   sram_cycle_seq i_sram_cycle_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .hold_cycles(hold_cycles), .done(done), .rdata(rdata),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_ce_n(mem_ce_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_park(input string req);
      check({mem_oe_n, mem_we_n, mem_ce_n} == 3'b111, req,
            {mem_oe_n, mem_we_n, mem_ce_n}, 3'b111);
      check(cmd_ready == 1'b1, req, cmd_ready, 1);
      check(mem_dq_oe == 1'b0, req, mem_dq_oe, 0);
   endtask

   task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d,
                         input logic [3:0] h);
      int hl;
      logic [2:0] exp_pat;
      hl = (h == 0) ? 1 : int'(h);
      cmd_valid   = 1'b1;
      cmd_write   = wr;
      cmd_addr    = a;
      cmd_wdata   = d;
      hold_cycles = h;
      mem_dq_in   = ~model[a];
      @(posedge clk);
      for (int i = 0; i < 3 * hl; i++) begin
         @(negedge clk);
         exp_pat = (i / hl == 1) ? (wr ? 3'b100 : 3'b010) : 3'b110;
         // R2 / R3 step patterns and step length (R7)
         check({mem_oe_n, mem_we_n, mem_ce_n} == exp_pat, wr ? "R2" : "R3",
               {mem_oe_n, mem_we_n, mem_ce_n}, exp_pat);
         check(mem_addr == a, wr ? "R4" : "R5", mem_addr, a);
         check(mem_dq_oe == wr, wr ? "R4" : "R5", mem_dq_oe, wr);
         if (wr) check(mem_dq_out == d, "R4", mem_dq_out, d);
         check(cmd_ready == 1'b0, "R8", cmd_ready, 0);
         check(done == 1'b0, "R9", done, 0);
         // R8 / R7: conflicting request and length change mid-cycle
         cmd_addr    = ~a;
         cmd_wdata   = ~d;
         cmd_write   = ~wr;
         hold_cycles = 4'd7;
         // R6: true byte only on last clock of middle step
         mem_dq_in = (i == 2 * hl - 1) ? model[a] : ~model[a];
      end
      @(negedge clk);
      check(done == 1'b1, "R9", done, 1);
      if (!wr) check(rdata == model[a], "R6", rdata, model[a]);
      check_park("R1");
      cmd_valid = 1'b0;
      if (wr) model[a] = d;
      @(negedge clk);
      check(done == 1'b0, "R9", done, 0);
      check_park("R1");
   endtask

   initial begin
      for (int k = 0; k < 256; k++) model[k] = 8'h00;
      repeat (3) @(negedge clk);
      check_park("R1");
      check(done == 1'b0, "R1", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_park("R1");
      // write every address, one clock per step
      for (int k = 0; k < 256; k++)
         access(1'b1, 8'(k), 8'(k * 37 + 11), 4'd1);
      // read every address with two clocks per step
      for (int k = 0; k < 256; k++)
         access(1'b0, 8'(k), 8'h00, 4'd2);
      // longer and zero lengths on a slice
      for (int k = 0; k < 32; k++)
         access(1'b1, 8'(k * 8), 8'(k * 37 + 11) ^ 8'h5A, 4'd3);
      for (int k = 0; k < 32; k++)
         access(1'b0, 8'(k * 8), 8'h00, 4'd4);
      for (int k = 0; k < 32; k++) begin
         access(1'b1, 8'(k * 8 + 1), 8'(k) ^ 8'hC3, 4'd0);
         access(1'b0, 8'(k * 8 + 1), 8'h00, 4'd0);
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         vectors++;
         misses++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end
endmodule